// File: doc/BRIEF.md
# Degradation Compensation Code Sequencer

This block is the digital control core of a laser-driver degradation monitor. A single free-running clock drives a repeating measurement frame. Each frame opens by clearing an external peak-hold stage and then opens a modulation-on window in which the held value follows the peak. Two sample strobes follow, both while modulation is off: the power path first, then the modulation path.

One cycle after each sample strobe ends, the block reads that path's comparator flag. A high flag means the sampled voltage fell below the path's reference, so compensation is needed. In that case one more 1 is shifted into that path's thermometer code.

The two codes feed the bias and modulation current compensation stages, which raise their current one step per set bit. A full code stays full and raises a per-path saturation flag. All analog parts lie outside the block and reach it only as the two flag inputs.

Top module: `degr_code_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the frame restarts and both codes clear to 0000. In the first cycle after release, `pk_clr` is high, `trk_on`, `smp_pwr` and `smp_mod` are low, and both saturation outputs are low.
- R2: Each frame lasts 3*PH_LEN + TRACK_LEN + 4*GAP cycles (14 by default). `pk_clr` is high for its first PH_LEN cycles and low for the rest of the frame.
- R3: `trk_on` (modulation on, peak tracking) is high for TRACK_LEN cycles, starting GAP cycles after `pk_clr` falls.
- R4: `smp_pwr` is high for PH_LEN cycles, starting GAP cycles after `trk_on` falls. `smp_mod` is high for PH_LEN cycles, starting GAP cycles after `smp_pwr` falls. Neither is ever high together with `trk_on`.
- R5: At most one of `pk_clr`, `trk_on`, `smp_pwr` and `smp_mod` is high in any cycle. At least one cycle with all four low separates adjacent phases.
- R6: `pwr_flag` is sampled only in the first cycle after `smp_pwr` falls, and `mod_flag` only in the first cycle after `smp_mod` falls. At all other times the flag levels have no effect on the codes.
- R7: A sampled high flag shifts a 1 into the low end of that path's code, so the code runs 0000, 0001, 0011, 0111, 1111. A sampled low flag leaves the code unchanged.
- R8: The power code (`pwr_code`) and the modulation code (`mod_code`) advance independently. A high flag on one path never changes the other path's code.
- R9: Once a code reaches 1111 it holds there, and its saturation output (`pwr_sat` or `mod_sat`) is high. A saturation output is high exactly when its code is 1111.
- R10: A code advances at most one step per frame, even when its flag stays high for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_flag | input | 1 | Power-path comparator result, high = below reference |
| mod_flag | input | 1 | Modulation-path comparator result, high = below reference |
| pk_clr | output | 1 | Clears the peak-hold stage |
| trk_on | output | 1 | Modulation-on window; peak hold tracks the maximum |
| smp_pwr | output | 1 | Power-path sample strobe |
| smp_mod | output | 1 | Modulation-path sample strobe |
| pwr_code | output | CODE_W | Power compensation thermometer code |
| mod_code | output | CODE_W | Modulation compensation thermometer code |
| pwr_sat | output | 1 | Power code is full |
| mod_sat | output | 1 | Modulation code is full |

## Verification
Both codes can change on the same frame. A frame can also present a high flag to a path whose code is already full. The bench holds both flags high for whole frames, both while the codes are climbing and after one of them has saturated. It then checks that each code took exactly one step or held at 1111, independently of the other path.

A second kind of test makes the flags toggle at every cycle except the two read cycles. It then checks that only the level seen in a read cycle changes a code.

// File: rtl/degr_code_seq.sv
module degr_code_seq #(
  parameter int PH_LEN    = 2,
  parameter int TRACK_LEN = 4,
  parameter int GAP       = 1,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_flag,
  input  logic              mod_flag,
  output logic              pk_clr,
  output logic              trk_on,
  output logic              smp_pwr,
  output logic              smp_mod,
  output logic [CODE_W-1:0] pwr_code,
  output logic [CODE_W-1:0] mod_code,
  output logic              pwr_sat,
  output logic              mod_sat
);

  localparam int FRAME = 3*PH_LEN + TRACK_LEN + 4*GAP;
  localparam int CW    = $clog2(FRAME + 1);

  localparam logic [CW-1:0] CLR_END = CW'(PH_LEN);
  localparam logic [CW-1:0] TRK_BEG = CW'(PH_LEN + GAP);
  localparam logic [CW-1:0] TRK_END = CW'(PH_LEN + GAP + TRACK_LEN);
  localparam logic [CW-1:0] PWR_BEG = CW'(PH_LEN + 2*GAP + TRACK_LEN);
  localparam logic [CW-1:0] PWR_END = CW'(2*PH_LEN + 2*GAP + TRACK_LEN);
  localparam logic [CW-1:0] MOD_BEG = CW'(2*PH_LEN + 3*GAP + TRACK_LEN);
  localparam logic [CW-1:0] MOD_END = CW'(3*PH_LEN + 3*GAP + TRACK_LEN);
  localparam logic [CW-1:0] LAST    = CW'(FRAME - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + CW'(1);
  end

  assign pk_clr  = cnt < CLR_END;
  assign trk_on  = (cnt >= TRK_BEG) && (cnt < TRK_END);
  assign smp_pwr = (cnt >= PWR_BEG) && (cnt < PWR_END);
  assign smp_mod = (cnt >= MOD_BEG) && (cnt < MOD_END);

  assign pwr_sat = pwr_code[CODE_W-1];
  assign mod_sat = mod_code[CODE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_code <= '0;
      mod_code <= '0;
    end else begin
      if (cnt == PWR_END && pwr_flag && !pwr_sat)
        pwr_code <= {pwr_code[CODE_W-2:0], 1'b1};
      if (cnt == MOD_END && mod_flag && !mod_sat)
        mod_code <= {mod_code[CODE_W-2:0], 1'b1};
    end
  end

  // R5
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pk_clr, trk_on, smp_pwr, smp_mod}));

  // R5
  phase_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pk_clr) || $fell(trk_on) || $fell(smp_pwr) || $fell(smp_mod))
      |-> !(pk_clr || trk_on || smp_pwr || smp_mod));

  // R7
  pwr_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_code & (pwr_code + CODE_W'(1))) == '0);

  // R7
  mod_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_code & (mod_code + CODE_W'(1))) == '0);

  // R6 R8 R10
  pwr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pwr_code) && $past(rst_n)) |-> ($past(pwr_flag) && $past(smp_pwr, 2) && !$past(smp_pwr)));

  // R6 R8 R10
  mod_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mod_code) && $past(rst_n)) |-> ($past(mod_flag) && $past(smp_mod, 2) && !$past(smp_mod)));

  // R9
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_sat |=> (pwr_sat && $stable(pwr_code)));

  // R9
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_sat |=> (mod_sat && $stable(mod_code)));

endmodule

// File: tb/degr_code_seq_test.sv
module degr_code_seq_test;
  localparam int FR  = 14;
  localparam int RDP = 10;
  localparam int RDM = 13;

  // {pwr_flag, mod_flag, expected pwr_code, expected mod_code}
  localparam logic [9:0] VEC [9] = '{
    {2'b00, 4'b0000, 4'b0000},
    {2'b10, 4'b0001, 4'b0000},
    {2'b01, 4'b0001, 4'b0001},
    {2'b11, 4'b0011, 4'b0011},
    {2'b10, 4'b0111, 4'b0011},
    {2'b10, 4'b1111, 4'b0011},
    {2'b11, 4'b1111, 4'b0111},
    {2'b01, 4'b1111, 4'b1111},
    {2'b11, 4'b1111, 4'b1111}
  };

  logic clk = 0, rst_n = 0, pwr_flag = 0, mod_flag = 0;
  logic pk_clr, trk_on, smp_pwr, smp_mod, pwr_sat, mod_sat;
  logic [3:0] pwr_code, mod_code;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  degr_code_seq uut (.clk(clk), .rst_n(rst_n), .pwr_flag(pwr_flag), .mod_flag(mod_flag),
    .pk_clr(pk_clr), .trk_on(trk_on), .smp_pwr(smp_pwr), .smp_mod(smp_mod),
    .pwr_code(pwr_code), .mod_code(mod_code), .pwr_sat(pwr_sat), .mod_sat(mod_sat));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_codes(input string req, input logic [3:0] ep, input logic [3:0] em);
    check(req, {8'h0, pwr_code, mod_code}, {8'h0, ep, em});
    check({req, " R9 sat"}, {14'h0, pwr_sat, mod_sat}, {14'h0, ep == 4'hF, em == 4'hF});
  endtask

  // One frame starting at a negedge with the frame at cycle 0.
  // Flag levels at the read cycle and elsewhere are set separately.
  task automatic frame(input logic pr, input logic po, input logic mr, input logic mo);
    for (int i = 0; i < FR; i++) begin
      pwr_flag = (i == RDP) ? pr : po;
      mod_flag = (i == RDM) ? mr : mo;
      // R2 R3 R4 R5 expected phase pattern per cycle
      check("R2 R3 R4 R5 strobes", {12'h0, pk_clr, trk_on, smp_pwr, smp_mod},
            {12'h0, i < 2, i >= 3 && i < 7, i >= 8 && i < 10, i >= 11 && i < 13});
      @(negedge clk);
    end
    pwr_flag = 0;
    mod_flag = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 state in the first cycle after release
    check_codes("R1 codes", 4'h0, 4'h0);
    check("R1 strobes", {12'h0, pk_clr, trk_on, smp_pwr, smp_mod}, 16'h0008);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R7 R8 R9 R10 vector walk, flags held high for whole frames
    for (int v = 0; v < 9; v++) begin
      frame(VEC[v][9], VEC[v][9], VEC[v][8], VEC[v][8]);
      check_codes($sformatf("R7 R8 R10 vec%0d", v), VEC[v][7:4], VEC[v][3:0]);
    end
    // R1 reset from saturated state
    do_reset();
    // R6 flags high everywhere except the read cycles: no effect
    frame(1'b0, 1'b1, 1'b0, 1'b1);
    check_codes("R6 ignored", 4'h0, 4'h0);
    // R6 flags high only in the read cycles: one step each
    frame(1'b1, 1'b0, 1'b1, 1'b0);
    check_codes("R6 read", 4'h1, 4'h1);
    // R8 only power path
    frame(1'b1, 1'b0, 1'b0, 1'b0);
    check_codes("R8 power only", 4'h3, 4'h1);
    // R8 only modulation path
    frame(1'b0, 1'b0, 1'b1, 1'b0);
    check_codes("R8 mod only", 4'h3, 4'h3);
    // R1 reset mid-frame
    repeat (5) @(negedge clk);
    do_reset();
    frame(1'b0, 1'b0, 1'b0, 1'b0);
    check_codes("R1 after midframe reset", 4'h0, 4'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule